// File: doc/BRIEF.md
# Stepped Soft-Start Limit Sequencer

This block produces the peak current-sense limit code that a switching regulator controller uses right after it is switched on. A one-cycle enable pulse starts a ramp that lasts four equal steps. The code begins at a level that stands for 0.3 V and ends at the normal limit, 0.8 V. Each step lasts a number of clock cycles set by an input, so a real part can use a 3 ms step and a simulation can use a few cycles. The full ramp then takes 12 ms.

When the last step has run out, the block raises a done flag and keeps the final code. Downstream logic uses the done flag to switch on frequency jitter and normal regulation. A new enable pulse restarts the ramp from the first step at any time, even partway through a ramp or after it has finished. The block only sequences the digital value. Comparators, the DAC and the feedback loop sit outside it.

Top module: `softstart_seq`

## Requirements
- R1: While reset is high, and after reset until the first enable, `limit_code` is 0 and `ramp_done` is 0. Reset is synchronous and active high.
- R2: An enable pulse sampled high on a rising clock edge starts the ramp. From the next cycle on, `limit_code` shows the start code 96, which is round(0.3/0.8 × 255).
- R3: The four step codes are 96 + floor(159 × k / 3) for k = 0..3, that is 96, 149, 202 and 255. The last step equals the final code 255, which stands for 0.8 V at full scale.
- R4: Each step code is held for exactly N cycles, where N is the value of `step_ticks` at the enable edge. A value of 0 is treated as 1.
- R5: `step_ticks` is captured only at the enable edge. Changing it during a ramp does not change the step lengths of that ramp.
- R6: Exactly 4×N cycles after the first start-code cycle, `ramp_done` goes to 1 and `limit_code` stays at 255. Both hold until reset or the next enable.
- R7: An enable during a ramp or after done clears `ramp_done` and shows the start code 96 again in the next cycle.
- R8: During a ramp with no new enable, `limit_code` never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Start or restart pulse |
| step_ticks | input | TICK_W | Cycles per step, captured at enable |
| limit_code | output | CODE_W | Peak current-sense limit code |
| ramp_done | output | 1 | Ramp finished, final code held |

## Verification
An enable sampled at a clock edge shows up on the outputs after that same edge. The state after that edge already carries the start code, and each later edge moves the ramp forward by one cycle. The code therefore changes every N edges, and done rises at the 4N-th edge after the first start-code state. The driver puts one expected output pair per clock edge into a queue at the moment it raises enable. The monitor samples 2 ns after each rising edge and pops one entry per edge, so every result is compared in exactly the cycle it is due. Resets applied mid-ramp are checked directly after the edge that samples them.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W     = 8,
  parameter int TICK_W     = 16,
  parameter int START_CODE = 96,
  parameter int FINAL_CODE = 255,
  parameter int STEPS      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TICK_W-1:0] step_ticks,
  output logic [CODE_W-1:0] limit_code,
  output logic              ramp_done
);
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  function automatic logic [CODE_W-1:0] level(input int k);
    return CODE_W'(START_CODE + ((FINAL_CODE - START_CODE) * k) / (STEPS - 1));
  endfunction

  logic [CODE_W-1:0] lvl [STEPS];
  for (genvar g = 0; g < STEPS; g++) begin : g_lvl
    assign lvl[g] = level(g);
  end

  logic              busy, done;
  logic [SW-1:0]     step;
  logic [TICK_W-1:0] cnt, last;

  wire cnt_end  = (cnt == last);
  wire step_end = (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
      cnt  <= '0;
      last <= '0;
    end else if (en) begin
      busy <= 1'b1;
      done <= 1'b0;
      step <= '0;
      cnt  <= '0;
      last <= (step_ticks == '0) ? '0 : step_ticks - TICK_W'(1);
    end else if (busy) begin
      if (cnt_end) begin
        cnt <= '0;
        if (step_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + SW'(1);
        end
      end else begin
        cnt <= cnt + TICK_W'(1);
      end
    end
  end

  assign limit_code = done ? CODE_W'(FINAL_CODE) : (busy ? lvl[step] : '0);
  assign ramp_done  = done;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (limit_code == '0 && !ramp_done));

  a_r7_restart_start: assert property (@(posedge clk) disable iff (rst)
    en |=> (limit_code == CODE_W'(START_CODE) && !ramp_done));

  a_r8_no_drop: assert property (@(posedge clk) disable iff (rst)
    (busy && !en) |=> (limit_code >= $past(limit_code)));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (ramp_done && !en) |=> (ramp_done && limit_code == CODE_W'(FINAL_CODE)));

  a_r6_done_entry: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_end && step_end && !en) |=> ramp_done);
endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] step_ticks = 16'd0;
  logic [7:0]  limit_code;
  logic        ramp_done;

  int total = 0;
  int bad   = 0;

  logic [7:0] q_code[$];
  logic       q_done[$];
  string      q_tag[$];
  logic [7:0] prev_code = 8'd0;

  always #5 clk = ~clk;

  softstart_seq u_dut (
    .clk(clk), .rst(rst), .en(en), .step_ticks(step_ticks),
    .limit_code(limit_code), .ramp_done(ramp_done)
  );

  function automatic logic [7:0] exp_level(input int k);
    return 8'(96 + (159 * k) / 3);
  endfunction

  task automatic check(input string tag, input logic [7:0] c, input logic d,
                       input logic [7:0] ec, input logic ed);
    total++;
    if (c !== ec || d !== ed) begin
      bad++;
      $display("FAIL %s: code=%0d done=%0d expected code=%0d done=%0d", tag, c, d, ec, ed);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q_code.size() > 0) begin
      logic [7:0] ec;
      logic       ed;
      string      tg;
      ec = q_code.pop_front();
      ed = q_done.pop_front();
      tg = q_tag.pop_front();
      check(tg, limit_code, ramp_done, ec, ed);
      if (tg == "R3") begin
        total++;
        if (limit_code < prev_code) begin
          bad++;
          $display("FAIL R8: code=%0d expected >= %0d", limit_code, prev_code);
        end
      end
      prev_code = limit_code;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      q_code.push_back(8'd0); q_done.push_back(1'b0); q_tag.push_back("R1");
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic ramp(input int n, input int len, input int alt, input string first_tag);
    int eff;
    eff = (n == 0) ? 1 : n;
    step_ticks = 16'(n);
    en = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (i < 4 * eff) begin
        q_code.push_back(exp_level(i / eff));
        q_done.push_back(1'b0);
        if (i == 0) q_tag.push_back(first_tag);
        else if (n == 0) q_tag.push_back("R4");
        else if (alt >= 0) q_tag.push_back("R5");
        else q_tag.push_back("R3");
      end else begin
        q_code.push_back(8'd255); q_done.push_back(1'b1); q_tag.push_back("R6");
      end
    end
    @(negedge clk);
    en = 1'b0;
    if (alt >= 0) step_ticks = 16'(alt);
    repeat (len - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", limit_code, ramp_done, 8'd0, 1'b0);
    rst = 1'b0;
    idle(3);
    ramp(3, 4 * 3 + 3, -1, "R2");
    ramp(1, 4 + 3, -1, "R7");
    ramp(0, 4 + 2, -1, "R7");
    ramp(5, 4 * 5 + 2, 2, "R7");
    ramp(4, 6, -1, "R7");
    ramp(2, 4 * 2 + 4, -1, "R7");
    ramp(4, 5, -1, "R7");
    rst = 1'b1;
    @(negedge clk);
    check("R1", limit_code, ramp_done, 8'd0, 1'b0);
    rst = 1'b0;
    idle(2);
    ramp(6, 4 * 6 + 2, 1, "R2");
    repeat (2) @(negedge clk);
    if (q_code.size() != 0) begin
      total++; bad++;
      $display("FAIL R6: pending=%0d expected 0", q_code.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule